// File: doc/BRIEF.md
# Keyed Watchdog and Software Reset Generator

This block turns two kinds of events into one internal reset pulse of fixed length. The first kind is a watchdog expiry. A counter runs while the enable input is high and expires after a power-of-two number of cycles, picked by a 3-bit period select. The second kind is a software request. Software asks for a reset by writing a two-byte unlock key to the key register on a simple byte-wide write bus.

A different two-byte key, written to the same key register, services the watchdog and clears its counter back to zero. Two sticky cause flags show which source caused a reset. Each flag stays set until power-on reset clears it, or until software writes a zero to that flag's clear bit in the control register.

Each key has its own detector, so the two sequences never disturb each other. A new cause that arrives while a pulse is running starts the full pulse length again.

Top module: `keyed_reset_gen`

## Requirements
- R1: A reset request makes `rst_out` rise on the clock edge that registers the request and stay high for exactly 16 cycles.
- R2: With `wdt_en` held high, the watchdog expires after exactly 2^(BASE_EXP+`period_sel`) counted cycles. The expiry starts a pulse and sets `flag_wdt`.
- R3: Two writes to key address 1, first 0x1E and then 0xE1, clear the watchdog counter. The next expiry then falls a full period after the edge of the 0xE1 write.
- R4: Two writes to key address 1, first 0x5A and then 0xA5, start a pulse and set `flag_sw` (software cause).
- R5: When the first key byte has been accepted, the next key-address write must be the matching second byte. Any other byte, including a repeat of the first byte or a byte of the other key, drops the partial sequence without effect.
- R6: The cause flags stay set through and after the pulse. On a write to control address 0, a 0 in bit 7 clears `flag_wdt` and a 0 in bit 6 clears `flag_sw`. A 1 in either bit leaves that flag unchanged.
- R7: While `wdt_en` is low, the watchdog counter is held at zero and no expiry occurs. Counting starts from zero when `wdt_en` goes high again.
- R8: A reset cause that arrives while a pulse is active reloads the pulse. `rst_out` then stays high for 16 cycles counted from that edge.
- R9: The watchdog counter is held at zero while the pulse is active. The next expiry falls a full period after the pulse ends.
- R10: If a restart key completes on the same edge as a watchdog expiry, the restart wins: no pulse, and the counter is cleared.
- R11: If a software key completes on the same edge as a watchdog expiry, one 16-cycle pulse is produced and both flags are set.
- R12: After power-on reset `rst_out` is low, both flags are clear, and neither key detector holds a partial sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wdt_en | input | 1 | Watchdog run enable |
| period_sel | input | 3 | Timeout select, period 2^(BASE_EXP+sel) cycles |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 key |
| wr_data | input | 8 | Write data byte |
| rst_out | output | 1 | Internal reset pulse |
| flag_wdt | output | 1 | Sticky watchdog-expiry cause flag |
| flag_sw | output | 1 | Sticky software-request cause flag |

## Verification
A key completion can fall on the same edge as a watchdog expiry. Both orderings are provoked. The bench counts a 16-cycle period to one cycle before expiry, then places the first key byte there and the second byte on the expiry edge itself. For the restart key it expects no pulse, and the next expiry exactly one period later. For the software key it expects a single 16-cycle pulse with both cause flags set.

// File: rtl/wdr_pkg.sv
package wdr_pkg;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 2;
    localparam int SEL_W     = 3;
    localparam int PULSE_LEN = 16;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = 2'd0;
    localparam logic [ADDR_W-1:0] KEY_ADDR  = 2'd1;

    // control write: a zero in these bits clears the matching flag
    localparam int CLR_WDT_BIT = 7;
    localparam int CLR_SW_BIT  = 6;

    typedef struct packed {
        logic [DATA_W-1:0] first;
        logic [DATA_W-1:0] second;
    } key_pair_t;

    localparam int N_KEYS      = 2;
    localparam int KEY_RESTART = 0;
    localparam int KEY_SOFT    = 1;

    localparam key_pair_t KEY_TABLE [N_KEYS] = '{
        '{first: 8'h1E, second: 8'hE1},
        '{first: 8'h5A, second: 8'hA5}
    };

    typedef struct packed {
        logic wdt;
        logic sw;
    } cause_t;

    // last count value before expiry for a given exponent offset
    function automatic logic [31:0] expiry_value(int unsigned base,
                                                 logic [SEL_W-1:0] sel);
        return (32'd1 << (base + 32'(sel))) - 32'd1;
    endfunction

endpackage

// File: rtl/wdr_key_seq.sv
module wdr_key_seq
    import wdr_pkg::*;
#(
    parameter logic [DATA_W-1:0] FIRST  = 8'h00,
    parameter logic [DATA_W-1:0] SECOND = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wr_data,
    output logic              fire
);

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_t;

    seq_t state, state_n;

    always_comb begin
        state_n = state;
        fire    = 1'b0;
        if (wr_hit) begin
            if (state == SEQ_ARMED) begin
                // any byte after the first ends the attempt
                state_n = SEQ_IDLE;
                fire    = (wr_data == SECOND);
            end else if (wr_data == FIRST) begin
                state_n = SEQ_ARMED;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SEQ_IDLE;
        else     state <= state_n;
    end

endmodule

// File: rtl/wdr_timeout.sv
module wdr_timeout
    import wdr_pkg::*;
#(
    parameter int BASE_EXP = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             expire
);

    localparam int MAX_EXP = BASE_EXP + (1 << SEL_W) - 1;
    localparam int CNT_W   = MAX_EXP + 1;

    logic [CNT_W-1:0] count;
    logic [31:0]      limit;
    logic             at_limit;

    always_comb begin
        limit    = expiry_value(BASE_EXP, sel);
        at_limit = (32'(count) == limit);
        // a restart on the expiry edge takes priority
        expire   = run && at_limit && !restart;
    end

    always_ff @(posedge clk) begin
        if (rst || !run || restart || at_limit)
            count <= '0;
        else
            count <= count + 1'b1;
    end

endmodule

// File: rtl/wdr_stretch.sv
module wdr_stretch
    import wdr_pkg::*;
#(
    parameter int LEN = PULSE_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic trigger,
    output logic active
);

    localparam int PW = $clog2(LEN + 1);

    logic [PW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (trigger)
            remain <= PW'(LEN);
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign active = (remain != '0);

endmodule

// File: rtl/keyed_reset_gen.sv
module keyed_reset_gen
    import wdr_pkg::*;
#(
    parameter int BASE_EXP = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wdt_en,
    input  logic [SEL_W-1:0]  period_sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rst_out,
    output logic              flag_wdt,
    output logic              flag_sw
);

    logic [N_KEYS-1:0] key_fire;
    logic              key_hit;
    logic              ctrl_hit;
    logic              pulse_active;
    logic              expire;
    logic              run;
    logic              trigger;
    cause_t            cause;

    assign key_hit  = wr_en && (wr_addr == KEY_ADDR);
    assign ctrl_hit = wr_en && (wr_addr == CTRL_ADDR);

    for (genvar k = 0; k < N_KEYS; k++) begin : g_key
        wdr_key_seq #(
            .FIRST (KEY_TABLE[k].first),
            .SECOND(KEY_TABLE[k].second)
        ) u_seq (
            .clk    (clk),
            .rst    (rst),
            .wr_hit (key_hit),
            .wr_data(wr_data),
            .fire   (key_fire[k])
        );
    end

    assign run = wdt_en && !pulse_active;

    wdr_timeout #(
        .BASE_EXP(BASE_EXP)
    ) u_timeout (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .restart(key_fire[KEY_RESTART]),
        .sel    (period_sel),
        .expire (expire)
    );

    assign trigger = expire || key_fire[KEY_SOFT];

    wdr_stretch #(
        .LEN(PULSE_LEN)
    ) u_stretch (
        .clk    (clk),
        .rst    (rst),
        .trigger(trigger),
        .active (pulse_active)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cause <= '0;
        end else begin
            if (expire)
                cause.wdt <= 1'b1;
            else if (ctrl_hit && !wr_data[CLR_WDT_BIT])
                cause.wdt <= 1'b0;
            if (key_fire[KEY_SOFT])
                cause.sw <= 1'b1;
            else if (ctrl_hit && !wr_data[CLR_SW_BIT])
                cause.sw <= 1'b0;
        end
    end

    assign rst_out  = pulse_active;
    assign flag_wdt = cause.wdt;
    assign flag_sw  = cause.sw;

endmodule

// File: rtl/wdr_checker.sv
module wdr_checker
    import wdr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wdt_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              rst_out,
    input logic              flag_wdt,
    input logic              flag_sw
);

    logic [7:0] high_len;

    always_ff @(posedge clk) begin
        if (rst)
            high_len <= '0;
        else if (rst_out)
            high_len <= (high_len == 8'hFF) ? high_len : high_len + 1'b1;
        else
            high_len <= '0;
    end

    // R1: no pulse ends before 16 high cycles
    a_r1_pulse_length: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_out) |-> (high_len >= 8'(PULSE_LEN)));

    // R2 / R4: a rising pulse always carries a recorded cause
    a_r2_cause_recorded: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_out) |-> (flag_wdt || flag_sw));

    // R4: the software flag only rises on a second soft key byte
    a_r4_sw_from_key: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_sw) |-> $past(wr_en && wr_addr == KEY_ADDR
                                 && wr_data == KEY_TABLE[KEY_SOFT].second));

    // R6: watchdog flag holds unless a clearing control write occurs
    a_r6_wdt_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_wdt && !(wr_en && wr_addr == CTRL_ADDR && !wr_data[CLR_WDT_BIT]))
        |=> flag_wdt);

    // R6: software flag holds unless a clearing control write occurs
    a_r6_sw_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_sw && !(wr_en && wr_addr == CTRL_ADDR && !wr_data[CLR_SW_BIT]))
        |=> flag_sw);

    // R7: with the watchdog disabled, only a soft key can start a pulse
    a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        ($rose(rst_out) && !$past(wdt_en)) |->
        $past(wr_en && wr_addr == KEY_ADDR
              && wr_data == KEY_TABLE[KEY_SOFT].second));

    // R9: the watchdog cannot fire again right after a pulse ends
    a_r9_no_immediate_refire: assert property (@(posedge clk) disable iff (rst)
        ($fell(rst_out) && !(wr_en && wr_addr == KEY_ADDR)) |=> !rst_out);

endmodule

bind keyed_reset_gen wdr_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .wdt_en  (wdt_en),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rst_out (rst_out),
    .flag_wdt(flag_wdt),
    .flag_sw (flag_sw)
);

// File: tb/keyed_reset_gen_tb.sv
`timescale 1ns/1ps
module keyed_reset_gen_tb;

    localparam int BASE = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wdt_en = 1'b0;
    logic [2:0] period_sel = 3'd0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       rst_out, flag_wdt, flag_sw;

    int vec = 0;
    int bad = 0;

    always #2 clk = ~clk;

    keyed_reset_gen #(.BASE_EXP(BASE)) u_dut (
        .clk(clk), .rst(rst), .wdt_en(wdt_en), .period_sel(period_sel),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rst_out(rst_out), .flag_wdt(flag_wdt), .flag_sw(flag_sw)
    );

    // expected is {rst_out, flag_wdt, flag_sw}
    task automatic chk(string tag, logic [2:0] exp);
        logic [2:0] act;
        act = {rst_out, flag_wdt, flag_sw};
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: {rst,wdt,sw} got %b expected %b at %0t",
                     tag, act, exp, $time);
        end
    endtask

    task automatic tk(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tk(1);
        wr_en = 1'b0;
    endtask

    task automatic por();
        rst = 1'b1; wdt_en = 1'b0; period_sel = 3'd0;
        tk(2);
        rst = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        logic [7:0] wrong [4];
        wrong = '{8'h00, 8'h1E, 8'h5A, 8'hE2};
        @(negedge clk);
        por();
        chk("R12 reset state", 3'b000);

        // R2, R1, R9 across every period select
        for (int s = 0; s < 8; s++) begin
            int len;
            len = 1 << (BASE + s);
            por();
            period_sel = 3'(s);
            wdt_en = 1'b1;
            tk(len - 1);  chk("R2 before expiry", 3'b000);
            tk(1);        chk("R2 expiry", 3'b110);
            tk(15);       chk("R1 last pulse cycle", 3'b110);
            tk(1);        chk("R1 pulse end", 3'b010);
            tk(len - 1);  chk("R9 counter cleared", 3'b010);
            tk(1);        chk("R9 next expiry", 3'b110);
            wdt_en = 1'b0;
            tk(16);       chk("R6 flag after pulse", 3'b010);
        end

        // R10 and R3: restart completes on the expiry edge
        por();
        wdt_en = 1'b1;
        tk(14);
        wr(2'd1, 8'h1E);
        wr(2'd1, 8'hE1);
        chk("R10 restart beats expiry", 3'b000);
        tk(15);  chk("R3 full period after restart", 3'b000);
        tk(1);   chk("R3 expiry after restart", 3'b110);
        wdt_en = 1'b0;
        tk(16);

        // R5: broken restart sequences do not service the watchdog
        for (int w = 0; w < 4; w++) begin
            por();
            wdt_en = 1'b1;
            wr(2'd1, 8'h1E);
            wr(2'd1, wrong[w]);
            wr(2'd1, 8'hE1);
            tk(12);  chk("R5 no restart yet", 3'b000);
            tk(1);   chk("R5 expiry unaffected", 3'b110);
            wdt_en = 1'b0;
            tk(16);
        end

        // R7: disabling clears the count
        por();
        wdt_en = 1'b1;
        tk(10);
        wdt_en = 1'b0;
        tk(40);  chk("R7 disabled no expiry", 3'b000);
        wdt_en = 1'b1;
        tk(15);  chk("R7 restart from zero", 3'b000);
        tk(1);   chk("R7 expiry after re-enable", 3'b110);
        wdt_en = 1'b0;
        tk(16);

        // R4: software reset
        por();
        wr(2'd1, 8'h5A);
        wr(2'd1, 8'hA5);
        chk("R4 soft pulse start", 3'b101);
        tk(15);  chk("R4 soft pulse last", 3'b101);
        tk(1);   chk("R4 soft pulse end", 3'b001);

        // R5: broken soft sequence
        wr(2'd1, 8'h5A);
        wr(2'd1, 8'h00);
        wr(2'd1, 8'hA5);
        chk("R5 broken soft key", 3'b001);
        tk(20);  chk("R5 no late pulse", 3'b001);

        // R6: flag clearing rules
        wdt_en = 1'b1;
        tk(16);  chk("R6 both flags", 3'b111);
        wdt_en = 1'b0;
        tk(16);  chk("R6 flags survive pulse", 3'b011);
        wr(2'd0, 8'hC0);  chk("R6 ones keep flags", 3'b011);
        wr(2'd0, 8'h80);  chk("R6 clear sw only", 3'b010);
        wr(2'd0, 8'h40);  chk("R6 clear wdt only", 3'b000);
        wr(2'd1, 8'h5A);
        wr(2'd1, 8'hA5);
        tk(20);
        chk("R6 sw set before por", 3'b001);
        por();
        chk("R12 por clears flags", 3'b000);

        // R8: retrigger mid-pulse
        wr(2'd1, 8'h5A);
        wr(2'd1, 8'hA5);
        tk(8);
        wr(2'd1, 8'h5A);
        wr(2'd1, 8'hA5);
        chk("R8 reload", 3'b101);
        tk(15);  chk("R8 extended pulse", 3'b101);
        tk(1);   chk("R8 extended end", 3'b001);

        // R11: soft key on the expiry edge
        por();
        wdt_en = 1'b1;
        tk(14);
        wr(2'd1, 8'h5A);
        wr(2'd1, 8'hA5);
        chk("R11 both causes", 3'b111);
        tk(15);  chk("R11 single pulse", 3'b111);
        tk(1);   chk("R11 pulse end", 3'b011);
        wdt_en = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule